// File: doc/BRIEF.md
# Monitor Channel Transmit Register Bank

This block holds one control register per port for the monitor channel transmitter of a four-port serial line interface. Each register carries a data byte, a ready flag and a last flag. Software writes a byte and sets ready to offer it to that port's transmitter. It sets last together with ready to ask for an end-of-message. In that case the line carries 0xFF, whatever the data field holds.

Each port's transmitter sees a held request with a data byte and an end-of-message qualifier. It answers with a one-cycle acknowledge. On an accepted acknowledge the block clears the port's flags and sets a sticky per-port status bit. A per-port enable mask gates these status bits into a single interrupt line. Software clears a status bit by writing a one to it. A synchronous software reset clears the same state as the asynchronous hardware reset.

Top module: `mon_tx_regs`

## Requirements
- R1: After the hardware reset (rst_n low) or a one-cycle soft_rst, every register reads 0x0000, tx_req and tx_eom are all low and irq is low.
- R2: Word index p (0..3) selects port p's register. Its layout is bit 9 last flag, bit 8 ready flag, bits 7:0 data byte. Bits 15:10 discard writes and read as zero.
- R3: tx_req[p] follows port p's ready flag. When the last flag is clear, tx_data[8p+7:8p] carries the stored data byte and tx_eom[p] is low.
- R4: When both last and ready are set, tx_eom[p] is high and tx_data for that port is 0xFF, regardless of the data field.
- R5: An acknowledge (tx_ack[p] high while tx_req[p] is high) clears both ready and last at that clock edge. The data byte is kept.
- R6: A register write that changes last from 1 to 0 also clears ready, whatever value is written to bit 8.
- R7: If a register write and an accepted acknowledge reach the same port in one cycle, the flags end up cleared. The written data byte is still stored.
- R8: Index 4 is the status register, with bit p for port p. An accepted acknowledge sets bit p. Writing a one clears a bit, and a set in the same cycle wins over the clear. An acknowledge without a request changes nothing.
- R9: Index 5 is the enable register, with bit p for port p. irq is high exactly when some status bit and its enable bit are both set.
- R10: Without an acknowledge, a register write or a reset, a raised tx_req stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous software reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word index (0..3 ports, 4 status, 5 enable) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the indexed register (combinational) |
| tx_req | output | 4 | Per-port transmit request |
| tx_eom | output | 4 | Per-port end-of-message qualifier |
| tx_data | output | 32 | Per-port byte, port p in bits 8p+7:8p |
| tx_ack | input | 4 | Per-port transmit acknowledge |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions assume that a transmitter drives its acknowledge for a single cycle, and only against a pending request. They also assume that no more than one bus write occurs per cycle. The hold and interrupt-rise checks tolerate software rewriting a register, because they exclude cycles with a write to the same index. The bench raises every acknowledge for exactly one cycle. It sends one acknowledge without a request, on purpose, to cover R8, and it issues writes one per cycle through a single task.

// File: rtl/mon_tx_regs.sv
module mon_tx_regs #(
  parameter int NPORT = 4,
  localparam int AW = $clog2(NPORT + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               bus_wr,
  input  logic [AW-1:0]      bus_addr,
  input  logic [15:0]        bus_wdata,
  output logic [15:0]        bus_rdata,
  output logic [NPORT-1:0]   tx_req,
  output logic [NPORT-1:0]   tx_eom,
  output logic [NPORT*8-1:0] tx_data,
  input  logic [NPORT-1:0]   tx_ack,
  output logic               irq
);
  localparam logic [AW-1:0] STS_IDX = AW'(NPORT);
  localparam logic [AW-1:0] EN_IDX  = AW'(NPORT + 1);

  logic [7:0]       data_q [NPORT];
  logic [NPORT-1:0] rdy_q, last_q, sts_q, en_q;
  logic [NPORT-1:0] wr_sel, acc, sts_clr;

  always_comb begin
    for (int p = 0; p < NPORT; p++) wr_sel[p] = bus_wr && (bus_addr == AW'(p));
  end

  assign acc     = tx_ack & rdy_q;
  assign sts_clr = (bus_wr && bus_addr == STS_IDX) ? bus_wdata[NPORT-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPORT; p++) data_q[p] <= '0;
      rdy_q  <= '0;
      last_q <= '0;
      sts_q  <= '0;
      en_q   <= '0;
    end else if (soft_rst) begin
      for (int p = 0; p < NPORT; p++) data_q[p] <= '0;
      rdy_q  <= '0;
      last_q <= '0;
      sts_q  <= '0;
      en_q   <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        if (wr_sel[p]) data_q[p] <= bus_wdata[7:0];
        if (acc[p]) begin
          rdy_q[p]  <= 1'b0;
          last_q[p] <= 1'b0;
        end else if (wr_sel[p]) begin
          last_q[p] <= bus_wdata[9];
          rdy_q[p]  <= bus_wdata[8] & ~(last_q[p] & ~bus_wdata[9]);
        end
      end
      if (bus_wr && bus_addr == EN_IDX) en_q <= bus_wdata[NPORT-1:0];
      sts_q <= acc | (sts_q & ~sts_clr);
    end
  end

  assign tx_req = rdy_q;
  assign tx_eom = rdy_q & last_q;
  assign irq    = |(sts_q & en_q);

  always_comb begin
    for (int p = 0; p < NPORT; p++)
      tx_data[p*8 +: 8] = tx_eom[p] ? 8'hFF : data_q[p];
  end

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NPORT; p++)
      if (bus_addr == AW'(p)) bus_rdata = {6'b0, last_q[p], rdy_q[p], data_q[p]};
    if (bus_addr == STS_IDX) bus_rdata[NPORT-1:0] = sts_q;
    if (bus_addr == EN_IDX)  bus_rdata[NPORT-1:0] = en_q;
  end
endmodule

module mon_tx_regs_chk #(
  parameter int NPORT = 4,
  parameter int AW = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               soft_rst,
  input logic               bus_wr,
  input logic [AW-1:0]      bus_addr,
  input logic [NPORT-1:0]   tx_req,
  input logic [NPORT-1:0]   tx_eom,
  input logic [NPORT*8-1:0] tx_data,
  input logic [NPORT-1:0]   tx_ack,
  input logic [NPORT-1:0]   sts,
  input logic               irq
);
  // R5
  ack_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ack & tx_req) != '0 |=> (tx_req & $past(tx_ack & tx_req)) == '0);

  // R8
  ack_sets_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_ack & tx_req) != '0 && !soft_rst) |=> (sts & $past(tx_ack & tx_req)) == $past(tx_ack & tx_req));

  // R9
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((tx_ack & tx_req) != '0 || bus_wr));

  // R1
  srst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (tx_req == '0 && !irq));

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    // R4
    eom_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_eom[p] |-> (tx_data[p*8 +: 8] == 8'hFF && tx_req[p]));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req[p] && !tx_ack[p] && !soft_rst && !(bus_wr && bus_addr == AW'(p))) |=> tx_req[p]);
  end
endmodule

bind mon_tx_regs mon_tx_regs_chk #(.NPORT(NPORT), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .tx_req(tx_req), .tx_eom(tx_eom), .tx_data(tx_data), .tx_ack(tx_ack),
  .sts(sts_q), .irq(irq)
);

// File: tb/mon_tx_regs_bench.sv
`timescale 1ns/1ps
module mon_tx_regs_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        soft_rst = 0;
  logic        bus_wr = 0;
  logic [2:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic [3:0]  tx_req, tx_eom, tx_ack = 0;
  logic [31:0] tx_data;
  logic        irq;

  int checks = 0, fails = 0;
  logic [10:0] exp_q[$];

  always #2.5 clk = ~clk;

  mon_tx_regs u_mon_tx_regs (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = idx; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rdchk(input logic [2:0] idx, input logic [15:0] exp, input string tag);
    @(negedge clk); bus_addr = idx; #1;
    chk(bus_rdata == exp, tag, 32'(bus_rdata), 32'(exp));
  endtask

  task automatic ack(input logic [3:0] m);
    @(negedge clk); tx_ack = m;
    @(negedge clk); tx_ack = 0;
  endtask

  task automatic wr_ack(input logic [2:0] idx, input logic [15:0] d, input logic [3:0] m);
    @(negedge clk); bus_wr = 1; bus_addr = idx; bus_wdata = d; tx_ack = m;
    @(negedge clk); bus_wr = 0; tx_ack = 0;
  endtask

  task automatic expect_tx(input logic [1:0] p, input logic eom, input logic [7:0] d);
    exp_q.push_back({p, eom, d});
  endtask

  // scoreboard monitor: compare each accepted handshake to the expected queue
  always begin
    @(negedge clk); #2;
    for (int p = 0; p < 4; p++) begin
      if (tx_ack[p] && tx_req[p]) begin
        logic [10:0] got;
        got = {2'(p), tx_eom[p], tx_data[p*8 +: 8]};
        if (exp_q.size() == 0) chk(0, "R3 unexpected transfer", 32'(got), 0);
        else begin
          logic [10:0] e;
          e = exp_q.pop_front();
          chk(got == e, "R3/R4 transfer", 32'(got), 32'(e));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int i = 0; i < 6; i++) rdchk(3'(i), 16'h0000, "R1 reset read");
    chk(tx_req == 0 && irq == 0, "R1 reset outputs", {tx_req, 3'b0, irq}, 0);

    // R2 / R3 plain byte
    wr(0, 16'h01A5);
    rdchk(0, 16'h01A5, "R2 readback");
    chk(tx_req[0] && !tx_eom[0] && tx_data[7:0] == 8'hA5, "R3 request", {tx_req, tx_eom, tx_data[7:0]}, {4'h1, 4'h0, 8'hA5});
    wr(1, 16'hFC3C);
    rdchk(1, 16'h003C, "R2 reserved bits");
    chk(!tx_req[1], "R2 reserved no ready", 32'(tx_req), 1);

    // R5 / R8 acknowledge
    expect_tx(0, 0, 8'hA5);
    ack(4'b0001);
    rdchk(0, 16'h00A5, "R5 ready cleared");
    rdchk(4, 16'h0001, "R8 status set");
    chk(!irq, "R9 masked irq", 32'(irq), 0);

    // R9 enable
    wr(5, 16'h000F);
    chk(irq, "R9 irq enabled", 32'(irq), 1);
    wr(4, 16'h0001);
    rdchk(4, 16'h0000, "R8 write one clears");
    chk(!irq, "R9 irq after clear", 32'(irq), 0);

    // R8 ack without request
    ack(4'b0010);
    rdchk(4, 16'h0000, "R8 ack without request");

    // R4 end-of-message, R10 hold
    wr(2, 16'h0312);
    chk(tx_eom[2] && tx_data[23:16] == 8'hFF, "R4 eom substitution", {tx_eom, tx_data[23:16]}, {4'h4, 8'hFF});
    repeat (3) @(negedge clk);
    chk(tx_req[2], "R10 request held", 32'(tx_req), 32'h4);
    expect_tx(2, 1, 8'hFF);
    ack(4'b0100);
    rdchk(2, 16'h0012, "R5 last and ready cleared");
    rdchk(4, 16'h0004, "R8 status eom port");

    // R6 clearing last clears ready
    wr(3, 16'h0377);
    wr(3, 16'h0177);
    rdchk(3, 16'h0077, "R6 last clear drops ready");
    chk(!tx_req[3], "R6 no request", 32'(tx_req), 0);

    // R7 write and ack collide
    wr(1, 16'h0111);
    expect_tx(1, 0, 8'h11);
    wr_ack(1, 16'h0322, 4'b0010);
    rdchk(1, 16'h0022, "R7 hardware clear wins");

    // R8 set wins over clear
    wr(0, 16'h0101);
    expect_tx(0, 0, 8'h01);
    wr_ack(4, 16'h0007, 4'b0001);
    rdchk(4, 16'h0001, "R8 set beats clear");
    chk(irq, "R9 irq from port0", 32'(irq), 1);

    // R1 software reset
    wr(2, 16'h0155);
    @(negedge clk); soft_rst = 1;
    @(negedge clk); soft_rst = 0;
    for (int i = 0; i < 6; i++) rdchk(3'(i), 16'h0000, "R1 soft reset read");
    chk(tx_req == 0 && !irq, "R1 soft reset outputs", {tx_req, 3'b0, irq}, 0);

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all expected transfers seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule